// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes divider and mode settings for a dual-section frequency synthesizer over a three-wire serial link. The link has a data line, a serial clock and a load strobe. All three lines are asynchronous to the system clock. They are brought into the system clock domain through a chain of flip-flops, and their edges are found there. Each detected rising edge of the serial clock pushes one data bit into a 23-bit word register. The word is sent most significant bit first, so the two routing bits are the last to arrive.

A rising edge of the load strobe decodes the two routing bits and copies the fields of the word into one of four destination latches. The four latches are:

- a reference latch for the low-frequency section;
- a reference latch for the high-frequency section;
- a counter latch for the low-frequency section;
- a counter latch for the high-frequency section.

Reference words and counter words use different field layouts. The latched values drive the synthesizer directly: the reference ratio, the main and swallow ratios, the prescaler choice, the phase polarity, the pump current choice and the monitor tap selection.

Top module: `sercfg_loader`

## Requirements
- R1: After reset, both sections hold these values: reference ratio 3, main ratio 3, swallow ratio 0, and every flag and tap bit 0.
- R2: Each rising edge of the serial clock, taken while the load strobe is low, shifts the data bit into bit 0 of the word register. The word keeps the last 23 bits received, with the earliest of them at bit 22, so any bits sent before those 23 have no effect.
- R3: At a load, bit 0 of the word picks the section (0 = low-frequency, 1 = high-frequency). Bit 1 of the word picks the kind of word (0 = reference word, 1 = counter word).
- R4: A reference word carries these fields: the two monitor tap bits at bits 2 and 3, the 14-bit reference ratio at bits 17..4 (least significant bit at bit 4), and the pump-current select at bit 18. Bits 22..19 are ignored.
- R5: A counter word carries these fields: the monitor enable at bit 2, the prescaler select at bit 3, the phase polarity at bit 4, the 7-bit swallow ratio at bits 11..5, and the 11-bit main ratio at bits 22..12.
- R6: A load updates only the addressed latch. The other three latches keep their contents.
- R7: Only a rising edge of the load strobe transfers a word. Shifting in bits, holding the strobe high, or a falling strobe leaves every output unchanged.
- R8: Serial clock edges that arrive while the load strobe is high do not shift the word register.
- R9: A load strobe rising just after a system clock edge shows on the outputs after exactly three system clock edges, and not after two (with the default two-stage synchronizer).
- R10: Fields are stored exactly as received across their full ranges. This includes a reference ratio of 3 or 16383, a main ratio of 2047 and a swallow ratio of 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdat_i | input | 1 | Serial data line (asynchronous) |
| sclk_i | input | 1 | Serial clock line (asynchronous) |
| sload_i | input | 1 | Load strobe (asynchronous) |
| lo_ref_div_o | output | 14 | Low section reference ratio |
| lo_tap_sel_o | output | 2 | Low section monitor tap bits |
| lo_pump_hi_o | output | 1 | Low section pump current select |
| lo_main_div_o | output | 11 | Low section main ratio |
| lo_swal_div_o | output | 7 | Low section swallow ratio |
| lo_mon_en_o | output | 1 | Low section monitor enable |
| lo_pre_sel_o | output | 1 | Low section prescaler select |
| lo_pol_o | output | 1 | Low section phase polarity |
| hi_ref_div_o | output | 14 | High section reference ratio |
| hi_tap_sel_o | output | 2 | High section monitor tap bits |
| hi_pump_hi_o | output | 1 | High section pump current select |
| hi_main_div_o | output | 11 | High section main ratio |
| hi_swal_div_o | output | 7 | High section swallow ratio |
| hi_mon_en_o | output | 1 | High section monitor enable |
| hi_pre_sel_o | output | 1 | High section prescaler select |
| hi_pol_o | output | 1 | High section phase polarity |

## Verification
A corrupted word register stays hidden until the next load strobe. It then shows as wrong field values in the addressed latch, three system clock edges after the strobe rises. To expose this, every load is followed by a comparison of all sixteen outputs.

A wrong routing decision overwrites a latch that should have held its value. That latch keeps the wrong value until it is reloaded, so the full comparison catches it at the same point. A bit that shifts while the load strobe is high changes the routing bits of the following load.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

   // field widths
   localparam int CTL_W  = 2;
   localparam int TAP_W  = 2;
   localparam int REF_W  = 14;
   localparam int SWL_W  = 7;
   localparam int MAIN_W = 11;
   localparam int NSEC   = 2;

   // reference word layout (positions above the routing bits)
   localparam int TAP_POS  = CTL_W;
   localparam int REF_POS  = TAP_POS + TAP_W;
   localparam int PUMP_POS = REF_POS + REF_W;
   localparam int REF_USED = PUMP_POS + 1;

   // counter word layout
   localparam int MON_POS  = CTL_W;
   localparam int PRE_POS  = MON_POS + 1;
   localparam int POL_POS  = PRE_POS + 1;
   localparam int SWL_POS  = POL_POS + 1;
   localparam int MAIN_POS = SWL_POS + SWL_W;
   localparam int CNT_USED = MAIN_POS + MAIN_W;

   // shift register length covers the longer of the two layouts
   localparam int WORD_W = (CNT_USED > REF_USED) ? CNT_USED : REF_USED;

   typedef logic [WORD_W-1:0] cfg_word_t;

   typedef struct packed {
      logic [REF_W-1:0] div;
      logic [TAP_W-1:0] tap;
      logic             pump_hi;
   } ref_fields_t;

   typedef struct packed {
      logic [MAIN_W-1:0] main_div;
      logic [SWL_W-1:0]  swal_div;
      logic              mon_en;
      logic              pre_sel;
      logic              pol;
   } cnt_fields_t;

   function automatic ref_fields_t unpack_ref(input cfg_word_t w);
      ref_fields_t f;
      f.div     = w[REF_POS +: REF_W];
      f.tap     = w[TAP_POS +: TAP_W];
      f.pump_hi = w[PUMP_POS];
      return f;
   endfunction

   function automatic cnt_fields_t unpack_cnt(input cfg_word_t w);
      cnt_fields_t f;
      f.main_div = w[MAIN_POS +: MAIN_W];
      f.swal_div = w[SWL_POS +: SWL_W];
      f.mon_en   = w[MON_POS];
      f.pre_sel  = w[PRE_POS];
      f.pol      = w[POL_POS];
      return f;
   endfunction

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] lvl_o
);

   logic [W-1:0] chain [STAGES];

   // one flop per stage; the first stage samples the pins
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign lvl_o = chain[STAGES-1];

endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift
   import sercfg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      shift_en,
   input  logic      din,
   output cfg_word_t word_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (shift_en) word_q <= {word_q[WORD_W-2:0], din};
   end

endmodule

// File: rtl/sercfg_section.sv
module sercfg_section
   import sercfg_pkg::*;
#(
   parameter int RST_REF  = 3,
   parameter int RST_MAIN = 3,
   parameter int RST_SWAL = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ref,
   input  logic        wr_cnt,
   input  cfg_word_t   word,
   output ref_fields_t ref_q,
   output cnt_fields_t cnt_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q.div     <= REF_W'(RST_REF);
         ref_q.tap     <= '0;
         ref_q.pump_hi <= 1'b0;
      end else if (wr_ref) begin
         ref_q <= unpack_ref(word);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q.main_div <= MAIN_W'(RST_MAIN);
         cnt_q.swal_div <= SWL_W'(RST_SWAL);
         cnt_q.mon_en   <= 1'b0;
         cnt_q.pre_sel  <= 1'b0;
         cnt_q.pol      <= 1'b0;
      end else if (wr_cnt) begin
         cnt_q <= unpack_cnt(word);
      end
   end

   // R6: a latch without its write strobe holds its value
   a_r6_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ref |=> $stable(ref_q));
   a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> $stable(cnt_q));

endmodule

// File: rtl/sercfg_loader.sv
module sercfg_loader
   import sercfg_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int RST_REF_DIV  = 3,
   parameter int RST_MAIN_DIV = 3,
   parameter int RST_SWAL_DIV = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdat_i,
   input  logic              sclk_i,
   input  logic              sload_i,
   output logic [REF_W-1:0]  lo_ref_div_o,
   output logic [TAP_W-1:0]  lo_tap_sel_o,
   output logic              lo_pump_hi_o,
   output logic [MAIN_W-1:0] lo_main_div_o,
   output logic [SWL_W-1:0]  lo_swal_div_o,
   output logic              lo_mon_en_o,
   output logic              lo_pre_sel_o,
   output logic              lo_pol_o,
   output logic [REF_W-1:0]  hi_ref_div_o,
   output logic [TAP_W-1:0]  hi_tap_sel_o,
   output logic              hi_pump_hi_o,
   output logic [MAIN_W-1:0] hi_main_div_o,
   output logic [SWL_W-1:0]  hi_swal_div_o,
   output logic              hi_mon_en_o,
   output logic              hi_pre_sel_o,
   output logic              hi_pol_o
);

   localparam int LN_DAT = 0;
   localparam int LN_CLK = 1;
   localparam int LN_LD  = 2;
   localparam int LANES  = 3;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sercfg_loader: SYNC_STAGES must be at least 2");
   end
   if (RST_REF_DIV < 3 || RST_REF_DIV >= (1 << REF_W)) begin : g_bad_ref
      $error("sercfg_loader: RST_REF_DIV out of range");
   end
   if (RST_MAIN_DIV < 3 || RST_MAIN_DIV >= (1 << MAIN_W)) begin : g_bad_main
      $error("sercfg_loader: RST_MAIN_DIV out of range");
   end
   if (RST_SWAL_DIV < 0 || RST_SWAL_DIV >= (1 << SWL_W)) begin : g_bad_swal
      $error("sercfg_loader: RST_SWAL_DIV out of range");
   end
   if (NSEC != 2) begin : g_bad_nsec
      $error("sercfg_loader: one routing bit selects the section, NSEC must be 2");
   end

   // synchronize the three pins
   logic [LANES-1:0] raw, lvl;
   assign raw = {sload_i, sclk_i, sdat_i};

   sercfg_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw),
      .lvl_o (lvl)
   );

   // edge detection in the system clock domain
   logic sclk_q, sld_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         sld_q  <= 1'b0;
      end else begin
         sclk_q <= lvl[LN_CLK];
         sld_q  <= lvl[LN_LD];
      end
   end

   logic sclk_rise, ld_rise, shift_en;
   assign sclk_rise = lvl[LN_CLK] & ~sclk_q;
   assign ld_rise   = lvl[LN_LD]  & ~sld_q;
   assign shift_en  = sclk_rise & ~lvl[LN_LD];

   cfg_word_t word;

   sercfg_shift u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (lvl[LN_DAT]),
      .word_q   (word)
   );

   // routing: bit 0 chooses the section, bit 1 the word kind
   logic [NSEC-1:0] wr_ref, wr_cnt;
   always_comb begin
      for (int s = 0; s < NSEC; s++) begin
         wr_ref[s] = ld_rise && (word[0] == s[0]) && !word[1];
         wr_cnt[s] = ld_rise && (word[0] == s[0]) &&  word[1];
      end
   end

   ref_fields_t ref_q [NSEC];
   cnt_fields_t cnt_q [NSEC];

   for (genvar g = 0; g < NSEC; g++) begin : g_sec
      sercfg_section #(
         .RST_REF  (RST_REF_DIV),
         .RST_MAIN (RST_MAIN_DIV),
         .RST_SWAL (RST_SWAL_DIV)
      ) u_sec (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_ref (wr_ref[g]),
         .wr_cnt (wr_cnt[g]),
         .word   (word),
         .ref_q  (ref_q[g]),
         .cnt_q  (cnt_q[g])
      );
   end

   assign lo_ref_div_o  = ref_q[0].div;
   assign lo_tap_sel_o  = ref_q[0].tap;
   assign lo_pump_hi_o  = ref_q[0].pump_hi;
   assign lo_main_div_o = cnt_q[0].main_div;
   assign lo_swal_div_o = cnt_q[0].swal_div;
   assign lo_mon_en_o   = cnt_q[0].mon_en;
   assign lo_pre_sel_o  = cnt_q[0].pre_sel;
   assign lo_pol_o      = cnt_q[0].pol;
   assign hi_ref_div_o  = ref_q[1].div;
   assign hi_tap_sel_o  = ref_q[1].tap;
   assign hi_pump_hi_o  = ref_q[1].pump_hi;
   assign hi_main_div_o = cnt_q[1].main_div;
   assign hi_swal_div_o = cnt_q[1].swal_div;
   assign hi_mon_en_o   = cnt_q[1].mon_en;
   assign hi_pre_sel_o  = cnt_q[1].pre_sel;
   assign hi_pol_o      = cnt_q[1].pol;

   // R8: while the strobe is high the word register does not move
   a_r8_no_shift_under_load: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[LN_LD] |=> $stable(word));

   // R2: the word register only moves on a serial clock edge
   a_r2_shift_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(word));

   // R6: exactly one latch strobed per load, none otherwise
   a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wr_ref, wr_cnt}) == (ld_rise ? 1 : 0));

   // R7: a held strobe yields a single transfer
   a_r7_single_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rise |=> !ld_rise);

endmodule

// File: tb/sercfg_loader_tb_top.sv
module sercfg_loader_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sdat = 1'b0, sclk = 1'b0, sload = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   logic [13:0] lo_ref, hi_ref;
   logic [1:0]  lo_tap, hi_tap;
   logic        lo_pump, hi_pump;
   logic [10:0] lo_main, hi_main;
   logic [6:0]  lo_swal, hi_swal;
   logic        lo_mon, hi_mon, lo_pre, hi_pre, lo_pol, hi_pol;

   sercfg_loader dut_i (
      .clk(clk), .rst_n(rst_n), .sdat_i(sdat), .sclk_i(sclk), .sload_i(sload),
      .lo_ref_div_o(lo_ref), .lo_tap_sel_o(lo_tap), .lo_pump_hi_o(lo_pump),
      .lo_main_div_o(lo_main), .lo_swal_div_o(lo_swal), .lo_mon_en_o(lo_mon),
      .lo_pre_sel_o(lo_pre), .lo_pol_o(lo_pol),
      .hi_ref_div_o(hi_ref), .hi_tap_sel_o(hi_tap), .hi_pump_hi_o(hi_pump),
      .hi_main_div_o(hi_main), .hi_swal_div_o(hi_swal), .hi_mon_en_o(hi_mon),
      .hi_pre_sel_o(hi_pre), .hi_pol_o(hi_pol)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   // expected state, index 0 = low section, 1 = high section
   logic [13:0] e_ref  [2];
   logic [1:0]  e_tap  [2];
   logic        e_pump [2];
   logic [10:0] e_main [2];
   logic [6:0]  e_swal [2];
   logic        e_mon  [2];
   logic        e_pre  [2];
   logic        e_pol  [2];

   function automatic logic [22:0] mk_ref(input bit hi, input logic [1:0] tap,
                                          input logic [13:0] r, input bit cs,
                                          input logic [3:0] dc);
      return {dc, cs, r, tap, 1'b0, hi};
   endfunction

   function automatic logic [22:0] mk_cnt(input bit hi, input logic [10:0] n,
                                          input logic [6:0] a, input bit pol,
                                          input bit pre, input bit mon);
      return {n, a, pol, pre, mon, 1'b1, hi};
   endfunction

   // bench model of a load: positions as stated in R3, R4, R5
   task automatic model_apply(input logic [22:0] w);
      int s;
      s = int'(w[0]);
      if (!w[1]) begin
         e_tap[s]  = {w[3], w[2]};
         e_ref[s]  = w[17:4];
         e_pump[s] = w[18];
      end else begin
         e_mon[s]  = w[2];
         e_pre[s]  = w[3];
         e_pol[s]  = w[4];
         e_swal[s] = w[11:5];
         e_main[s] = w[22:12];
      end
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "lo ref",  int'(lo_ref),  int'(e_ref[0]));
      chk(req, "lo tap",  int'(lo_tap),  int'(e_tap[0]));
      chk(req, "lo pump", int'(lo_pump), int'(e_pump[0]));
      chk(req, "lo main", int'(lo_main), int'(e_main[0]));
      chk(req, "lo swal", int'(lo_swal), int'(e_swal[0]));
      chk(req, "lo mon",  int'(lo_mon),  int'(e_mon[0]));
      chk(req, "lo pre",  int'(lo_pre),  int'(e_pre[0]));
      chk(req, "lo pol",  int'(lo_pol),  int'(e_pol[0]));
      chk(req, "hi ref",  int'(hi_ref),  int'(e_ref[1]));
      chk(req, "hi tap",  int'(hi_tap),  int'(e_tap[1]));
      chk(req, "hi pump", int'(hi_pump), int'(e_pump[1]));
      chk(req, "hi main", int'(hi_main), int'(e_main[1]));
      chk(req, "hi swal", int'(hi_swal), int'(e_swal[1]));
      chk(req, "hi mon",  int'(hi_mon),  int'(e_mon[1]));
      chk(req, "hi pre",  int'(hi_pre),  int'(e_pre[1]));
      chk(req, "hi pol",  int'(hi_pol),  int'(e_pol[1]));
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) sdat = b;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_bits(input logic [63:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
   endtask

   task automatic pulse_load();
      @(negedge clk) sload = 1'b1;
      repeat (4) @(negedge clk);
      sload = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // shift a word, confirm nothing moved (R7), then load and compare
   task automatic load_word(input logic [22:0] w, input int junk_n,
                            input logic [7:0] junk, input string req);
      send_bits({33'd0, junk, w}, 23 + junk_n);
      check_all("R7 shift without strobe");
      pulse_load();
      model_apply(w);
      check_all(req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [22:0] w;
      void'($urandom(32'h1F2E3D4C));
      for (int s = 0; s < 2; s++) begin
         e_ref[s] = 14'd3; e_tap[s] = 2'd0; e_pump[s] = 1'b0;
         e_main[s] = 11'd3; e_swal[s] = 7'd0;
         e_mon[s] = 1'b0; e_pre[s] = 1'b0; e_pol[s] = 1'b0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R1 reset values");

      // R9 latency on a low-section reference word (R3, R4)
      w = mk_ref(1'b0, 2'b10, 14'd1234, 1'b1, 4'b0000);
      send_bits({41'd0, w}, 23);
      @(negedge clk) sload = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 not before third edge", "lo ref", int'(lo_ref), 3);
      @(negedge clk);
      chk("R9 after third edge", "lo ref", int'(lo_ref), 1234);
      repeat (2) @(negedge clk);
      sload = 1'b0;
      repeat (4) @(negedge clk);
      model_apply(w);
      check_all("R3 R4 R6 lo reference");

      // remaining three destinations, ignored bits set in a reference word
      load_word(mk_ref(1'b1, 2'b01, 14'd16383, 1'b0, 4'b1111), 0, 8'd0,
                "R3 R4 R6 R10 hi reference max ratio");
      load_word(mk_cnt(1'b0, 11'd2047, 7'd127, 1'b1, 1'b0, 1'b1), 0, 8'd0,
                "R3 R5 R6 R10 lo counter max ratios");
      load_word(mk_cnt(1'b1, 11'd3, 7'd0, 1'b0, 1'b1, 1'b0), 0, 8'd0,
                "R3 R5 R6 hi counter min ratios");
      load_word(mk_ref(1'b1, 2'b11, 14'd3, 1'b1, 4'b1010), 0, 8'd0,
                "R4 R10 hi reference min ratio");

      // R2: leading extra bits fall off the top of the word
      load_word(mk_cnt(1'b0, 11'd1029, 7'd85, 1'b0, 1'b1, 1'b1), 7, 8'h7F,
                "R2 extra leading bits dropped");

      // R8: serial clock pulses under a held strobe must not shift
      w = mk_ref(1'b0, 2'b01, 14'd777, 1'b0, 4'b0000);
      load_word(w, 0, 8'd0, "R4 R6 before held strobe");
      @(negedge clk) sload = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk) sdat = 1'b1;
         repeat (3) @(negedge clk);
         sclk = 1'b1;
         repeat (3) @(negedge clk);
         sclk = 1'b0;
         repeat (2) @(negedge clk);
      end
      sload = 1'b0;
      repeat (4) @(negedge clk);
      check_all("R7 R8 held strobe single transfer");
      pulse_load();
      check_all("R8 reload of unshifted word");

      // constrained random words with random leading junk
      for (int k = 0; k < 40; k++) begin
         int jn;
         logic [7:0] jb;
         w  = 23'($urandom());
         jn = int'($urandom_range(0, 3));
         jb = 8'($urandom());
         load_word(w, jn, jb, "R2 R3 R4 R5 R6 random word");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule